// File: doc/BRIEF.md
# Two-Channel Disk Controller Interrupt and Bus-Master Register Block

This block holds the interrupt and bus-master register state of a two-channel disk host controller. Each channel drives a request level into the block. A rising level sets that channel's interrupt flag and a falling level clears it. Software can also clear a flag by writing a one to it. The flag of each channel can be read at two configuration bytes: a per-channel status byte and a shared mode byte. It can also be read through the bus-master window. Because each flag is held as one bit of state, every view of it always shows the same value.

The shared mode byte also holds one block bit per channel. The registered interrupt output is high when any channel has its flag set and its block bit clear. The bus-master window is 16 bytes. Channel 0 uses offsets 0 to 3 and channel 1 uses offsets 8 to 11. In each group the four bytes are the command byte, the mode byte, the status byte and the channel's timing byte. Only byte-wide window accesses take effect.

The transfer engine is not part of this block. It drives the active bit and the two event bits of each channel's status byte through dedicated inputs.

Top module: `ide_irq_regs`

## Requirements
- R1: A synchronous active-high reset clears all of the following to zero: the interrupt flags, the block bits, the command, status and timing bytes, both read-data registers and the interrupt output.
- R2: The channel 0 flag appears at configuration byte 0x71 bit 2 and configuration byte 0x50 bit 2. The channel 1 flag appears at byte 0x71 bit 3 and byte 0x57 bit 4. Both flags also appear at window offsets 1 and 9 in the byte 0x71 layout. A rising edge on a channel's request input sets its flag and a falling edge clears it, at one clock edge for all views.
- R3: A configuration write clears a channel's flag in every view when it writes 1 to that flag's bit at byte 0x50, 0x57 or 0x71. Writing 0 to a flag bit has no effect. A configuration write can never set a flag or change a block bit. When a request rising edge and a clear arrive in the same cycle, the flag is set.
- R4: The interrupt output equals (flag0 AND NOT block0) OR (flag1 AND NOT block1). It is registered, so it changes on the same clock edge as the flags and block bits.
- R5: The block bits are byte 0x71 bits 4 (channel 0) and 5 (channel 1). A byte write to window offset 1 or 9 loads those two bits from write data bits 4 and 5. The same write leaves both flags unchanged.
- R6: A byte write to window offset 2 or 10 sets that channel's status byte to (wdata & 0x60) | (old & 0x01) | (old & ~wdata & 0x06). Bits 3, 4 and 7 read as zero.
- R7: Status bit 0 follows the channel's dma_active input with one cycle of delay. A pulse on dma_err_set sets bit 1 and a pulse on dma_done_set sets bit 2. Each set wins over a clear in the same cycle.
- R8: Window offsets 0 and 8 are plain read/write command bytes. The timing bytes appear at window offsets 3 and 11 and also at configuration bytes 0x73 and 0x7B. They are readable and writable at both places.
- R9: A window access with bm_wide high returns 0xFF when read and changes no state when written.
- R10: Read data is registered and appears the cycle after the read strobe. Window offsets 4-7 and 12-15 read 0x00, and so does any configuration byte not listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_re | input | 1 | Configuration byte read strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, one cycle after cfg_re |
| chan_req | input | 2 | Per-channel interrupt request level |
| bm_we | input | 1 | Window write strobe |
| bm_re | input | 1 | Window read strobe |
| bm_wide | input | 1 | Access is wider than one byte |
| bm_addr | input | 4 | Window byte offset |
| bm_wdata | input | 8 | Window write data |
| bm_rdata | output | 8 | Window read data, one cycle after bm_re |
| dma_active | input | 2 | Per-channel transfer-active level (status bit 0) |
| dma_err_set | input | 2 | Per-channel error event pulse (status bit 1) |
| dma_done_set | input | 2 | Per-channel done event pulse (status bit 2) |
| irq | output | 1 | Level-sensitive interrupt output |

## Verification
The flag logic is driven by a table that mixes three kinds of stimulus: request edges, configuration clears and window block writes. Each step is followed by a read of the mode byte and a sample of the interrupt output. The table includes blocked flags, request levels that stay high after a clear, and writes of zero to flag bits. This separates a block bit that only masks the output from one that wrongly clears the flag. It also separates edge-triggered request handling from level-triggered handling. Directed steps then cover the following:
- reading the same flag at every view;
- a request rising edge in the same cycle as a clear;
- the mixed status write rule, with write data chosen so that the sticky, read-only and plain bit groups each give a different result;
- wide accesses that must leave the timing byte and the block bits unchanged.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int DW = 8;
  localparam int NCH = 2;
  localparam logic [7:0] CFG_FLAG0 = 8'h50;
  localparam logic [7:0] CFG_FLAG1 = 8'h57;
  localparam logic [7:0] CFG_MODE  = 8'h71;
  localparam logic [7:0] CFG_TIM0  = 8'h73;
  localparam logic [7:0] CFG_TIM1  = 8'h7B;
  localparam logic [1:0] BM_CMD  = 2'd0;
  localparam logic [1:0] BM_MODE = 2'd1;
  localparam logic [1:0] BM_STAT = 2'd2;
  localparam logic [1:0] BM_TIM  = 2'd3;

  // mixed write rule of the status byte
  function automatic logic [DW-1:0] stat_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] wd);
    return (wd & 8'h60) | (old_v & 8'h01) | (old_v & ~wd & 8'h06);
  endfunction
endpackage

// File: rtl/ide_irq_flag.sv
module ide_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic clr,
  output logic flag_nxt,
  output logic flag_q
);
  logic req_q;
  logic req_rise, req_fall;

  assign req_rise = req & ~req_q;
  assign req_fall = ~req & req_q;

  always_comb begin
    flag_nxt = flag_q;
    if (clr) flag_nxt = 1'b0;
    if (req_fall) flag_nxt = 1'b0;
    if (req_rise) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q  <= req;
      flag_q <= flag_nxt;
    end
  end

  // R3
  flag_only_req_sets_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(req));

  // R2
  flag_fall_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && !req) |=> !flag_q);
endmodule

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic          stat_we,
  input  logic          tim_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] tim_wdata,
  input  logic          act,
  input  logic          err_set,
  input  logic          done_set,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] tim_q
);
  logic [DW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_we ? stat_merge(stat_q, wdata) : stat_q;
    stat_nxt[0] = act;
    if (err_set)  stat_nxt[1] = 1'b1;
    if (done_set) stat_nxt[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      stat_q <= '0;
      tim_q  <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (cmd_we) cmd_q <= wdata;
      if (tim_we) tim_q <= tim_wdata;
    end
  end

  // R6
  stat_plain_bits_chk: assert property (@(posedge clk) disable iff (rst)
    stat_we |=> stat_q[6:5] == $past(wdata[6:5]));

  // R6
  stat_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_we && wdata[1] && !err_set) |=> !stat_q[1]);

  // R7
  stat_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_set |=> stat_q[1]);
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int BM_AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [NCH-1:0]    chan_req,
  input  logic              bm_we,
  input  logic              bm_re,
  input  logic              bm_wide,
  input  logic [BM_AW-1:0]  bm_addr,
  input  logic [DW-1:0]     bm_wdata,
  output logic [DW-1:0]     bm_rdata,
  input  logic [NCH-1:0]    dma_active,
  input  logic [NCH-1:0]    dma_err_set,
  input  logic [NCH-1:0]    dma_done_set,
  output logic              irq
);
  logic [NCH-1:0] flag_q, flag_nxt, clr;
  logic [NCH-1:0] blk_q, blk_nxt;
  logic [DW-1:0]  cmd_q  [NCH];
  logic [DW-1:0]  stat_q [NCH];
  logic [DW-1:0]  tim_q  [NCH];
  logic [DW-1:0]  mode_byte;
  logic           bm_byte_we, bm_lo;
  logic [1:0]     bm_reg;
  logic           bm_ch;
  logic           irq_q;

  assign bm_byte_we = bm_we && !bm_wide;
  assign bm_lo      = !bm_addr[2];
  assign bm_reg     = bm_addr[1:0];
  assign bm_ch      = bm_addr[3];

  assign clr[0] = cfg_we && cfg_wdata[2] &&
                  (cfg_addr == CFG_AW'(CFG_FLAG0) || cfg_addr == CFG_AW'(CFG_MODE));
  assign clr[1] = cfg_we && ((cfg_addr == CFG_AW'(CFG_FLAG1) && cfg_wdata[4]) ||
                             (cfg_addr == CFG_AW'(CFG_MODE)  && cfg_wdata[3]));

  assign mode_byte = {2'b00, blk_q, flag_q, 2'b00};

  always_comb begin
    blk_nxt = blk_q;
    if (bm_byte_we && bm_lo && bm_reg == BM_MODE) blk_nxt = bm_wdata[5:4];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [7:0] TADDR = (c == 0) ? CFG_TIM0 : CFG_TIM1;
    logic sel, bm_tim_we, cfg_tim_we;
    assign sel        = bm_byte_we && bm_lo && (bm_ch == 1'(c));
    assign bm_tim_we  = sel && bm_reg == BM_TIM;
    assign cfg_tim_we = cfg_we && cfg_addr == CFG_AW'(TADDR);

    ide_irq_flag u_flag (
      .clk(clk), .rst(rst), .req(chan_req[c]), .clr(clr[c]),
      .flag_nxt(flag_nxt[c]), .flag_q(flag_q[c])
    );

    ide_bm_chan u_bm (
      .clk(clk), .rst(rst),
      .cmd_we(sel && bm_reg == BM_CMD),
      .stat_we(sel && bm_reg == BM_STAT),
      .tim_we(bm_tim_we || cfg_tim_we),
      .wdata(bm_wdata),
      .tim_wdata(bm_tim_we ? bm_wdata : cfg_wdata),
      .act(dma_active[c]), .err_set(dma_err_set[c]), .done_set(dma_done_set[c]),
      .cmd_q(cmd_q[c]), .stat_q(stat_q[c]), .tim_q(tim_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q     <= '0;
      irq_q     <= 1'b0;
      cfg_rdata <= '0;
      bm_rdata  <= '0;
    end else begin
      blk_q <= blk_nxt;
      irq_q <= |(flag_nxt & ~blk_nxt);
      if (cfg_re) begin
        case (cfg_addr)
          CFG_AW'(CFG_FLAG0): cfg_rdata <= {5'b0, flag_q[0], 2'b00};
          CFG_AW'(CFG_FLAG1): cfg_rdata <= {3'b0, flag_q[1], 4'b0000};
          CFG_AW'(CFG_MODE):  cfg_rdata <= mode_byte;
          CFG_AW'(CFG_TIM0):  cfg_rdata <= tim_q[0];
          CFG_AW'(CFG_TIM1):  cfg_rdata <= tim_q[1];
          default:            cfg_rdata <= '0;
        endcase
      end
      if (bm_re) begin
        if (bm_wide)     bm_rdata <= '1;
        else if (!bm_lo) bm_rdata <= '0;
        else begin
          case (bm_reg)
            BM_CMD:  bm_rdata <= cmd_q[bm_ch];
            BM_MODE: bm_rdata <= mode_byte;
            BM_STAT: bm_rdata <= stat_q[bm_ch];
            default: bm_rdata <= tim_q[bm_ch];
          endcase
        end
      end
    end
  end

  assign irq = irq_q;

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flag_q & ~blk_q));

  // R3
  cfg_no_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !bm_we) |=> $stable(blk_q));

  // R9
  wide_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bm_we && bm_wide && !cfg_we) |=> $stable(blk_q) && $stable(tim_q[0]) && $stable(tim_q[1]));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_q && blk_q == '0 && flag_q == '0));
endmodule

// File: tb/test_ide_irq_regs.sv
module test_ide_irq_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 0, cfg_re = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic [1:0] chan_req = 0;
  logic       bm_we = 0, bm_re = 0, bm_wide = 0;
  logic [3:0] bm_addr = 0;
  logic [7:0] bm_wdata = 0, bm_rdata;
  logic [1:0] dma_active = 0, dma_err_set = 0, dma_done_set = 0;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ide_irq_regs i_ide_irq_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chan_req(chan_req),
    .bm_we(bm_we), .bm_re(bm_re), .bm_wide(bm_wide), .bm_addr(bm_addr),
    .bm_wdata(bm_wdata), .bm_rdata(bm_rdata), .dma_active(dma_active),
    .dma_err_set(dma_err_set), .dma_done_set(dma_done_set), .irq(irq)
  );

  // op: 0 request level, 1 config write, 2 window byte write
  localparam int NV = 20;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {2'd0, 8'h00, 8'h01, 8'h04, 1'b1},
    {2'd2, 8'h01, 8'h10, 8'h14, 1'b0},
    {2'd0, 8'h00, 8'h03, 8'h1C, 1'b1},
    {2'd2, 8'h09, 8'h30, 8'h3C, 1'b0},
    {2'd2, 8'h01, 8'h0C, 8'h0C, 1'b1},
    {2'd1, 8'h50, 8'h04, 8'h08, 1'b1},
    {2'd1, 8'h71, 8'h30, 8'h08, 1'b1},
    {2'd1, 8'h57, 8'h10, 8'h00, 1'b0},
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b0},
    {2'd0, 8'h00, 8'h02, 8'h08, 1'b1},
    {2'd1, 8'h71, 8'h08, 8'h00, 1'b0},
    {2'd0, 8'h00, 8'h03, 8'h04, 1'b1},
    {2'd1, 8'h50, 8'hFB, 8'h04, 1'b1},
    {2'd1, 8'h71, 8'hF3, 8'h04, 1'b1},
    {2'd0, 8'h00, 8'h02, 8'h00, 1'b0},
    {2'd2, 8'h01, 8'h20, 8'h20, 1'b0},
    {2'd0, 8'h00, 8'h00, 8'h20, 1'b0},
    {2'd0, 8'h00, 8'h02, 8'h28, 1'b0},
    {2'd2, 8'h09, 8'h00, 8'h08, 1'b1},
    {2'd0, 8'h00, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_re = 1; cfg_addr = a;
    @(negedge clk); d = cfg_rdata; cfg_re = 0;
  endtask

  task automatic bm_wr(input logic [3:0] a, input logic [7:0] d, input logic w);
    @(negedge clk); bm_we = 1; bm_wide = w; bm_addr = a; bm_wdata = d;
    @(negedge clk); bm_we = 0; bm_wide = 0;
  endtask

  task automatic bm_rd(input logic [3:0] a, input logic w, output logic [7:0] d);
    @(negedge clk); bm_re = 1; bm_wide = w; bm_addr = a;
    @(negedge clk); d = bm_rdata; bm_re = 0; bm_wide = 0;
  endtask

  task automatic set_req(input logic [1:0] v);
    @(negedge clk); chan_req = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    logic [7:0] rd;
    do_reset();
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    cfg_rd(8'h71, rd); chk("R1 mode", rd, 8'h00);
    bm_rd(4'd2, 0, rd); chk("R1 status", rd, 8'h00);
    bm_rd(4'd3, 0, rd); chk("R1 timing", rd, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] a, d, e;
      logic       ei;
      {op, a, d, e, ei} = VEC[i];
      case (op)
        2'd0: set_req(d[1:0]);
        2'd1: cfg_wr(a, d);
        default: bm_wr(a[3:0], d, 0);
      endcase
      chk(op == 2'd0 ? "R2 vec irq" : (op == 2'd1 ? "R3 vec irq" : "R5 vec irq"),
          {7'd0, irq}, {7'd0, ei});
      cfg_rd(8'h71, rd);
      chk(op == 2'd0 ? "R2 vec mode" : (op == 2'd1 ? "R3 vec mode" : "R5 vec mode"), rd, e);
      chk("R4 irq after read", {7'd0, irq}, {7'd0, ei});
    end

    // R2 every view of the flags
    set_req(2'b11);
    cfg_rd(8'h50, rd); chk("R2 byte50", rd, 8'h04);
    cfg_rd(8'h57, rd); chk("R2 byte57", rd, 8'h10);
    bm_rd(4'd1, 0, rd); chk("R2 win1", rd, 8'h0C);
    bm_rd(4'd9, 0, rd); chk("R2 win9", rd, 8'h0C);
    cfg_wr(8'h57, 8'h10);
    cfg_rd(8'h71, rd); chk("R3 clear57 mirrored", rd, 8'h04);
    bm_rd(4'd9, 0, rd); chk("R3 clear57 window", rd, 8'h04);
    set_req(2'b10);
    cfg_rd(8'h50, rd); chk("R2 fall byte50", rd, 8'h00);
    // R3 request rise and clear in the same cycle
    @(negedge clk); chan_req = 2'b11; cfg_we = 1; cfg_addr = 8'h50; cfg_wdata = 8'h04;
    @(negedge clk); cfg_we = 0;
    cfg_rd(8'h71, rd); chk("R3 rise beats clear", rd, 8'h04);
    set_req(2'b00);

    // R7 status set inputs
    @(negedge clk); dma_active = 2'b01; dma_err_set = 2'b01; dma_done_set = 2'b01;
    @(negedge clk); dma_err_set = 0; dma_done_set = 0;
    bm_rd(4'd2, 0, rd); chk("R7 status set", rd, 8'h07);
    bm_rd(4'd10, 0, rd); chk("R7 other channel", rd, 8'h00);
    // R6 mixed write rule
    bm_wr(4'd2, 8'h62, 0);
    bm_rd(4'd2, 0, rd); chk("R6 write 62", rd, 8'h65);
    bm_wr(4'd2, 8'h9F, 0);
    bm_rd(4'd2, 0, rd); chk("R6 write 9F", rd, 8'h01);
    @(negedge clk); dma_active = 2'b00;
    @(negedge clk);
    bm_rd(4'd2, 0, rd); chk("R7 active follows", rd, 8'h00);

    // R8 timing and command bytes
    bm_wr(4'd3, 8'hA5, 0);
    bm_wr(4'd11, 8'h5A, 0);
    cfg_rd(8'h73, rd); chk("R8 tim0 cfg", rd, 8'hA5);
    cfg_rd(8'h7B, rd); chk("R8 tim1 cfg", rd, 8'h5A);
    cfg_wr(8'h7B, 8'h3C);
    bm_rd(4'd11, 0, rd); chk("R8 tim1 window", rd, 8'h3C);
    bm_wr(4'd8, 8'h09, 0);
    bm_rd(4'd8, 0, rd); chk("R8 cmd1", rd, 8'h09);
    bm_rd(4'd0, 0, rd); chk("R8 cmd0", rd, 8'h00);

    // R9 wide accesses
    bm_rd(4'd3, 1, rd); chk("R9 wide read", rd, 8'hFF);
    bm_wr(4'd3, 8'h00, 1);
    bm_rd(4'd3, 0, rd); chk("R9 wide write timing", rd, 8'hA5);
    set_req(2'b01);
    bm_wr(4'd1, 8'h10, 1);
    chk("R9 wide write block", {7'd0, irq}, 8'h01);
    cfg_rd(8'h71, rd); chk("R9 mode after wide", rd, 8'h04);

    // R10 unmapped reads
    bm_rd(4'd5, 0, rd); chk("R10 window hole", rd, 8'h00);
    cfg_rd(8'h40, rd); chk("R10 cfg hole", rd, 8'h00);

    // R1 reset in mid run
    do_reset();
    chk("R1 irq again", {7'd0, irq}, 8'h00);
    bm_rd(4'd3, 0, rd); chk("R1 timing again", rd, 8'h00);
    bm_rd(4'd8, 0, rd); chk("R1 cmd again", rd, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule